// File: doc/BRIEF.md
# Word Shifter with Carry Generation

This block shifts a 32-bit word left or right in one pass. A right shift can be logical, which fills with zeros, or arithmetic, which copies the sign bit in. The shift count comes from one of two places. The first is a 6-bit register amount, whose top bit marks an out-of-range shift. The second is a 5-bit immediate count. The block is used as the shift stage of an integer execution pipe.

For arithmetic right shifts the block also produces a carry flag. The flag reports whether a negative operand lost any 1 bits. The special rules for a zero count and an out-of-range count depend on which count source was used. Logical shifts leave the carry flag untouched. The result and the flag are registered, and they appear one cycle after the input strobe with their own valid pulse.

Top module: `word_shifter_carry`

## Requirements
- R1: `out_valid` goes high exactly one clock edge after an edge at which `in_valid` is high. After an edge with `in_valid` low, `out_valid` is low and `out_result` and `out_carry` keep their values.
- R2: With `in_imm_sel`=1 the count is `in_imm`, which is never out of range, and `in_amt` has no effect. With `in_imm_sel`=0 the count is `in_amt[4:0]`, and `in_amt[5]` marks out of range.
- R3: Op code 2'b00 (and 2'b11, treated the same way) is a logical left shift with zero fill. When the register count has bit 5 set, the result is 0.
- R4: Op code 2'b01 is a logical right shift with zero fill. When the register count has bit 5 set, the result is 0.
- R5: Op code 2'b10 is an arithmetic right shift. When the count is in range, the vacated upper bits take the value of operand bit 31.
- R6: For an arithmetic shift with register count bit 5 set, the result is all ones if the operand is negative and 0 otherwise.
- R7: For an in-range arithmetic shift by n>0, the carry is 1 only when the operand is negative and at least one of its low n bits is 1.
- R8: For an out-of-range arithmetic shift, the carry is 1 only when the operand is negative and bits 30:0 are not all zero.
- R9: For an arithmetic shift with a register count of exactly 0 (all six bits clear), the result equals the operand and the carry is 1.
- R10: For an arithmetic shift with an immediate count of 0, the result equals the operand and the carry is 0.
- R11: Logical shifts (op codes 00, 01, 11) leave `out_carry` unchanged.
- R12: After reset, `out_valid`, `out_result` and `out_carry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_op | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 left |
| in_imm_sel | input | 1 | 1 selects the immediate count |
| in_amt | input | 6 | Register shift amount; bit 5 means out of range |
| in_imm | input | 5 | Immediate shift count |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Carry flag |

## Verification
An operation that holds the carry flag can land on the cycle right after one that sets it. In that cycle a new result is loaded while the old carry has to survive. The bench issues back-to-back streams that mix arithmetic shifts producing carry 1 with logical shifts, and it compares the carry against a bench model that only updates on arithmetic ops. A second collision is between the zero-count rule and the choice of count source: the same operand is shifted by register count 0 and by immediate count 0 in adjacent cycles, and the two must give opposite carries.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   typedef enum logic [1:0] {
      WSC_SHL     = 2'b00,
      WSC_SHR     = 2'b01,
      WSC_SRA     = 2'b10,
      WSC_SHL_ALT = 2'b11
   } wsc_op_e;
endpackage

// File: rtl/wsc_amount_sel.sv
module wsc_amount_sel #(
   parameter int AMT_W = 5
) (
   input  logic             imm_sel,
   input  logic [AMT_W:0]   reg_amt,
   input  logic [AMT_W-1:0] imm_amt,
   output logic [AMT_W-1:0] count,
   output logic             over,
   output logic             zero_reg,
   output logic             zero_imm
);
   always_comb begin
      if (imm_sel) begin
         count    = imm_amt;
         over     = 1'b0;
         zero_reg = 1'b0;
         zero_imm = (imm_amt == '0);
      end else begin
         count    = reg_amt[AMT_W-1:0];
         over     = reg_amt[AMT_W];
         zero_reg = (reg_amt == '0);
         zero_imm = 1'b0;
      end
   end
endmodule

// File: rtl/wsc_barrel.sv
module wsc_barrel #(
   parameter int WIDTH = 32,
   parameter int AMT_W = 5
) (
   input  logic [WIDTH-1:0] data,
   input  logic [AMT_W-1:0] count,
   input  logic             go_left,
   input  logic             fill,
   output logic [WIDTH-1:0] shifted,
   output logic             lost_any
);
   logic [WIDTH-1:0] data_rev;
   logic [WIDTH-1:0] stg_rev;
   logic [WIDTH-1:0] stg [0:AMT_W];

   // Left shifts reuse the right-shift ladder on the mirrored word.
   for (genvar b = 0; b < WIDTH; b++) begin : g_mirror
      assign data_rev[b] = data[WIDTH-1-b];
      assign stg_rev[b]  = stg[AMT_W][WIDTH-1-b];
   end

   assign stg[0] = go_left ? data_rev : data;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stg[k+1] = count[k] ? {{S{fill}}, stg[k][WIDTH-1:S]} : stg[k];
   end

   assign shifted  = go_left ? stg_rev : stg[AMT_W];
   // Low `count` bits of the operand leave the word on a right shift.
   assign lost_any = |(data & ~({WIDTH{1'b1}} << count));
endmodule

// File: rtl/wsc_carry.sv
module wsc_carry (
   input  logic sign,
   input  logic low_nz,
   input  logic lost_any,
   input  logic over,
   input  logic zero_reg,
   input  logic zero_imm,
   output logic carry_next
);
   always_comb begin
      if (zero_reg)      carry_next = 1'b1;
      else if (zero_imm) carry_next = 1'b0;
      else if (over)     carry_next = sign & low_nz;
      else               carry_next = sign & lost_any;
   end
endmodule

// File: rtl/word_shifter_carry.sv
module word_shifter_carry #(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic             in_imm_sel,
   input  logic [AMT_W:0]   in_amt,
   input  logic [AMT_W-1:0] in_imm,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_result,
   output logic             out_carry
);
   import wsc_pkg::*;

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("word_shifter_carry: WIDTH must be a power of two of at least 4");
   end

   wsc_op_e          op;
   logic [AMT_W-1:0] count;
   logic             over, zero_reg, zero_imm;
   logic             is_sra, go_left, sign;
   logic [WIDTH-1:0] shifted, result_next;
   logic             lost_any, carry_next;

   assign op      = wsc_op_e'(in_op);
   assign is_sra  = (op == WSC_SRA);
   assign go_left = (op == WSC_SHL) || (op == WSC_SHL_ALT);
   assign sign    = in_data[WIDTH-1];

   wsc_amount_sel #(.AMT_W(AMT_W)) u_amt (
      .imm_sel (in_imm_sel),
      .reg_amt (in_amt),
      .imm_amt (in_imm),
      .count   (count),
      .over    (over),
      .zero_reg(zero_reg),
      .zero_imm(zero_imm)
   );

   wsc_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
      .data    (in_data),
      .count   (count),
      .go_left (go_left),
      .fill    (is_sra & sign),
      .shifted (shifted),
      .lost_any(lost_any)
   );

   wsc_carry u_carry (
      .sign      (sign),
      .low_nz    (|in_data[WIDTH-2:0]),
      .lost_any  (lost_any),
      .over      (over),
      .zero_reg  (zero_reg),
      .zero_imm  (zero_imm),
      .carry_next(carry_next)
   );

   always_comb begin
      if (over) result_next = is_sra ? {WIDTH{sign}} : '0;
      else      result_next = shifted;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_carry  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= result_next;
            if (is_sra) out_carry <= carry_next;
         end
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));
   assert_logical_keeps_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op != 2'b10) |=> $stable(out_carry));
   assert_logical_oor_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_imm_sel && in_amt[AMT_W] && in_op != 2'b10) |=> (out_result == '0));
   assert_sra_keeps_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10) |=> (out_result[WIDTH-1] == $past(in_data[WIDTH-1])));
   assert_positive_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10 && !in_data[WIDTH-1] && !(!in_imm_sel && in_amt == '0))
      |=> !out_carry);
   assert_regzero_sets_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10 && !in_imm_sel && in_amt == '0) |=> out_carry);
endmodule

// File: tb/tb_word_shifter_carry.sv
`timescale 1ns/1ps
module tb_word_shifter_carry;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic        in_imm_sel = 1'b0;
   logic [5:0]  in_amt = '0;
   logic [4:0]  in_imm = '0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_carry;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   logic model_carry = 1'b0;

   logic [31:0] q_res[$];
   logic        q_cy[$];
   string       q_tag[$];

   word_shifter_carry dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_imm_sel(in_imm_sel), .in_amt(in_amt), .in_imm(in_imm),
      .in_data(in_data), .out_valid(out_valid), .out_result(out_result),
      .out_carry(out_carry)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: applies one op at the falling edge and pushes the expected outcome.
   task automatic drive(input logic [1:0] op, input bit isel, input logic [5:0] amt,
                        input logic [4:0] imm, input logic [31:0] d, input string tag);
      logic [31:0] r;
      int n;
      bit oor;
      n   = isel ? int'(imm) : int'(amt[4:0]);
      oor = !isel && amt[5];
      if (op == 2'b10) begin
         if (oor) begin
            r = d[31] ? 32'hFFFF_FFFF : 32'h0;
            model_carry = d[31] && (d[30:0] != 0);
         end else begin
            r = 32'($signed(d) >>> n);
            if (!isel && amt == 0)      model_carry = 1'b1;
            else if (isel && imm == 0)  model_carry = 1'b0;
            else model_carry = d[31] && ((d & ((32'h1 << n) - 1)) != 0);
         end
      end else if (op == 2'b01) begin
         r = oor ? 32'h0 : (d >> n);
      end else begin
         r = oor ? 32'h0 : (d << n);
      end
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_imm_sel = isel;
      in_amt = amt; in_imm = imm; in_data = d;
      q_res.push_back(r); q_cy.push_back(model_carry); q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data = $urandom;
         in_amt = 6'($urandom);
      end
   endtask

   // Monitor: compares every output strobe against the queue head.
   logic [31:0] last_res;
   logic        last_cy;
   bit          seen = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q_res.size() == 0) begin
               check(1'b0, "R1 unexpected out_valid", 32'd1, 32'd0);
            end else begin
               logic [31:0] er;
               logic        ec;
               string       t;
               er = q_res.pop_front(); ec = q_cy.pop_front(); t = q_tag.pop_front();
               check(out_result == er, {t, " result"}, out_result, er);
               check(out_carry == ec, {t, " carry"}, 32'(out_carry), 32'(ec));
            end
         end else if (seen) begin
            check(out_result == last_res && out_carry == last_cy,
                  "R1 hold while idle", out_result, last_res);
         end
         last_res = out_result; last_cy = out_carry; seen = 1'b1;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_result == 32'h0 && out_carry == 1'b0,
            "R12 reset state", {out_result[30:0], out_valid}, 32'h0);
      rst_n = 1'b1;
      // R3 left shifts, incl. alternate code and out-of-range
      drive(2'b00, 0, 6'd4,  0, 32'h0000_00F1, "R3 shl 4");
      drive(2'b00, 0, 6'd31, 0, 32'h0000_0003, "R3 shl 31");
      drive(2'b11, 0, 6'd8,  0, 32'h1234_5678, "R3 alt code shl 8");
      drive(2'b00, 0, 6'd33, 0, 32'hFFFF_FFFF, "R3 shl out of range");
      // R4 logical right
      drive(2'b01, 0, 6'd1,  0, 32'h8000_0001, "R4 shr 1");
      drive(2'b01, 0, 6'd63, 0, 32'hFFFF_FFFF, "R4 shr out of range");
      // R5/R7 arithmetic in range
      drive(2'b10, 0, 6'd4, 0, 32'hF000_0010, "R5 R7 sra neg no lost ones");
      drive(2'b10, 0, 6'd4, 0, 32'hF000_0018, "R7 sra neg lost one");
      drive(2'b01, 0, 6'd2, 0, 32'h0000_0100, "R11 shr keeps carry 1");
      drive(2'b00, 1, 6'd0, 5'd3, 32'h0000_0001, "R11 imm shl keeps carry 1");
      drive(2'b10, 0, 6'd31, 0, 32'h7FFF_FFFF, "R5 R7 sra positive");
      drive(2'b10, 1, 6'd0, 5'd31, 32'h8000_0000, "R7 imm sra 31 neg");
      drive(2'b10, 1, 6'd0, 5'd31, 32'h8000_0001, "R7 imm sra 31 lost");
      // R6/R8 out of range
      drive(2'b10, 0, 6'd32, 0, 32'h8000_0000, "R6 R8 oor neg low zero");
      drive(2'b10, 0, 6'd40, 0, 32'h8000_0001, "R6 R8 oor neg low nonzero");
      drive(2'b10, 0, 6'd63, 0, 32'h7FFF_FFFF, "R6 R8 oor positive");
      // R9/R10 zero counts, adjacent
      drive(2'b10, 0, 6'd0, 0, 32'h0000_0005, "R9 reg zero");
      drive(2'b10, 1, 6'd0, 5'd0, 32'h0000_0005, "R10 imm zero");
      drive(2'b10, 0, 6'd0, 0, 32'hC000_0000, "R9 reg zero neg");
      drive(2'b10, 1, 6'd0, 5'd0, 32'hC000_0001, "R10 imm zero neg");
      // R2 immediate path ignores in_amt
      drive(2'b01, 1, 6'd32, 5'd4, 32'hABCD_0000, "R2 imm ignores amt bit5");
      drive(2'b10, 1, 6'd0,  5'd1, 32'h8000_0001, "R2 imm ignores zero amt");
      idle(3);
      drive(2'b00, 1, 6'd63, 5'd0, 32'h0F0F_0F0F, "R2 R11 imm shl 0");
      idle(1);
      for (int i = 0; i < 40; i++)
         drive(2'($urandom), 1'($urandom), 6'($urandom), 5'($urandom), $urandom,
               "R3 R4 R5 R7 mixed stream");
      idle(4);
      check(q_res.size() == 0, "R1 all results delivered", q_res.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL R1 watchdog: actual %0d expected %0d", cycles, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule